// File: doc/BRIEF.md
# Skewed Four-Bank Transpose Buffer

This block sits between two radix-4 butterfly stages of a streaming FFT pipeline and reorders a 16-point frame. Each accepted input beat carries four complex samples, one row of the frame. Input row r holds samples X(4r) to X(4r+3). The block stores each row across four single-write, single-read memory banks. The row is rotated by its own index, so that any stride-4 group of samples lies in four different banks. After the last row of a frame has been accepted, the block reads one diagonal per cycle. A rotator puts the lanes back in order. Each output beat therefore carries Xi, Xi+4, Xi+8 and Xi+12, which is the operand set the next butterfly needs.

Every bank holds two frames. Writes fill one half while reads drain the other. A new frame can therefore stream in directly behind the previous one, and four samples per cycle flow in and out without a stall. The handshake is valid-only in both directions. The upstream stage may leave gaps between rows, and the downstream stage must accept every output beat.

Top module: `skew_transpose_buf`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid is low. Reset returns the write position to row 0 of the first half, so a partly written frame is dropped and the next accepted row starts a new frame.
- R2: Lane j of input row r is sample X(4r+j), carried on bits [j*SAMPLE_W +: SAMPLE_W] of in_re and in_im. In output beat i (i = 0..3), lane t carries X(i+4t) on the same bit positions of out_re and out_im.
- R3: For each completed frame, out_valid is high for exactly four consecutive cycles, carrying groups i = 0, 1, 2, 3 in that order. Frames leave in the order they arrived.
- R4: Group 0 of a frame is on the outputs in the cycle directly after the edge that accepted the frame's fourth row. out_valid stays low while that frame is still incomplete.
- R5: A cycle with in_valid low consumes no row, and the data lanes are ignored in that cycle. Rows of one frame may be separated by any number of idle cycles.
- R6: When frames arrive back to back, each frame is written into the other half while the previous frame is being read. out_valid then stays high without a bubble across frame boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input row present this cycle |
| in_re | input | LANES*SAMPLE_W | Real parts of the four input lanes |
| in_im | input | LANES*SAMPLE_W | Imaginary parts of the four input lanes |
| out_valid | output | 1 | Output group present this cycle |
| out_re | output | LANES*SAMPLE_W | Real parts of the four output lanes |
| out_im | output | LANES*SAMPLE_W | Imaginary parts of the four output lanes |

## Verification
The hardest case to reach is a frame whose write overlaps the read of the previous frame in the other half. The last read of the old frame and the completion of the new one fall on the same edge, and nothing at the ports announces that overlap. The stimulus reaches it by sending three frames with no idle cycle between rows or frames. The bench then checks that the output run is twelve cycles long and carries every group in order. Frames with idle gaps and random data on the lanes during those gaps show that unaccepted beats leave the stored rows alone. A reset in the middle of a frame, followed by a clean frame, shows that the write position restarts.

// File: rtl/skew_pkg.sv
`timescale 1ns/1ps
package skew_pkg;

    // Selects which half of every bank a frame occupies.
    typedef enum logic {
        HALF_A = 1'b0,
        HALF_B = 1'b1
    } half_e;

    function automatic half_e other_half(input half_e h);
        return (h == HALF_A) ? HALF_B : HALF_A;
    endfunction

    function automatic int unsigned mod_add(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned m);
        return (a + b) % m;
    endfunction

    function automatic int unsigned mod_sub(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned m);
        return (a + m - (b % m)) % m;
    endfunction

endpackage

// File: rtl/skew_bank.sv
`timescale 1ns/1ps
// One storage bank: one write port, one asynchronous read port.
module skew_bank #(
    parameter int W      = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [W-1:0]      wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [W-1:0]      rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/skew_rotate.sv
`timescale 1ns/1ps
// Lane rotator. REVERSE=1: dout[j] = din[(j - sel) mod LANES]
//               REVERSE=0: dout[j] = din[(j + sel) mod LANES]
module skew_rotate #(
    parameter int LANES   = 4,
    parameter int W       = 32,
    parameter int SEL_W   = 2,
    parameter bit REVERSE = 1'b0
) (
    input  logic [W-1:0]     din  [LANES],
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     dout [LANES]
);
    logic [W-1:0] cand [LANES][LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        for (genvar s = 0; s < LANES; s++) begin : g_shift
            if (REVERSE) begin : g_rev
                localparam int SRC = skew_pkg::mod_sub(j, s, LANES);
                assign cand[j][s] = din[SRC];
            end else begin : g_fwd
                localparam int SRC = skew_pkg::mod_add(j, s, LANES);
                assign cand[j][s] = din[SRC];
            end
        end
        assign dout[j] = cand[j][sel];
    end

endmodule

// File: rtl/skew_seq.sv
`timescale 1ns/1ps
// Row counter, half selection and diagonal read sequencing.
module skew_seq
    import skew_pkg::*;
#(
    parameter int LANES = 4,
    parameter int ROW_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic [ROW_W-1:0] wr_row,
    output half_e            wr_half,
    output logic             frame_done,
    output logic             rd_active,
    output logic [ROW_W-1:0] rd_grp,
    output half_e            rd_half
);
    localparam logic [ROW_W-1:0] LAST = ROW_W'(LANES - 1);

    assign frame_done = in_valid && (wr_row == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_row    <= '0;
            wr_half   <= HALF_A;
            rd_active <= 1'b0;
            rd_grp    <= '0;
            rd_half   <= HALF_A;
        end else begin
            if (in_valid) begin
                wr_row <= wr_row + 1'b1;
            end
            if (frame_done) begin
                wr_half   <= other_half(wr_half);
                rd_active <= 1'b1;
                rd_grp    <= '0;
                rd_half   <= wr_half;
            end else if (rd_active) begin
                if (rd_grp == LAST) begin
                    rd_active <= 1'b0;
                end
                rd_grp <= rd_grp + 1'b1;
            end
        end
    end

endmodule

// File: rtl/skew_transpose_buf.sv
`timescale 1ns/1ps
module skew_transpose_buf
    import skew_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int SAMPLE_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [LANES*SAMPLE_W-1:0] in_re,
    input  logic [LANES*SAMPLE_W-1:0] in_im,
    output logic                      out_valid,
    output logic [LANES*SAMPLE_W-1:0] out_re,
    output logic [LANES*SAMPLE_W-1:0] out_im
);
    localparam int ROW_W  = $clog2(LANES);
    localparam int ADDR_W = ROW_W + 1;
    localparam int CW     = 2 * SAMPLE_W;

    logic [CW-1:0]     lane_in  [LANES];
    logic [CW-1:0]     bank_wd  [LANES];
    logic [CW-1:0]     bank_rd  [LANES];
    logic [CW-1:0]     lane_out [LANES];
    logic [ADDR_W-1:0] rd_addr  [LANES];

    logic [ROW_W-1:0] wr_row;
    logic [ROW_W-1:0] rd_grp;
    half_e            wr_half;
    half_e            rd_half;
    logic             frame_done;
    logic             rd_active;

    skew_seq #(.LANES(LANES), .ROW_W(ROW_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .wr_row     (wr_row),
        .wr_half    (wr_half),
        .frame_done (frame_done),
        .rd_active  (rd_active),
        .rd_grp     (rd_grp),
        .rd_half    (rd_half)
    );

    // Row r is spread so that lane j lands in bank (j + r) mod LANES.
    skew_rotate #(.LANES(LANES), .W(CW), .SEL_W(ROW_W), .REVERSE(1'b1)) u_wr_rot (
        .din  (lane_in),
        .sel  (wr_row),
        .dout (bank_wd)
    );

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        assign lane_in[b] = {in_im[b*SAMPLE_W +: SAMPLE_W], in_re[b*SAMPLE_W +: SAMPLE_W]};
        // Diagonal read: bank b supplies row (b - group) mod LANES.
        assign rd_addr[b] = {logic'(rd_half), ROW_W'(b) - rd_grp};

        skew_bank #(.W(CW), .ADDR_W(ADDR_W)) u_bank (
            .clk   (clk),
            .we    (in_valid),
            .waddr ({logic'(wr_half), wr_row}),
            .wdata (bank_wd[b]),
            .raddr (rd_addr[b]),
            .rdata (bank_rd[b])
        );

        assign out_re[b*SAMPLE_W +: SAMPLE_W] = lane_out[b][SAMPLE_W-1:0];
        assign out_im[b*SAMPLE_W +: SAMPLE_W] = lane_out[b][CW-1:SAMPLE_W];
    end

    // Output lane t takes bank (t + group) mod LANES.
    skew_rotate #(.LANES(LANES), .W(CW), .SEL_W(ROW_W), .REVERSE(1'b0)) u_rd_rot (
        .din  (bank_rd),
        .sel  (rd_grp),
        .dout (lane_out)
    );

    assign out_valid = rd_active;

endmodule

// File: rtl/skew_transpose_buf_chk.sv
`timescale 1ns/1ps
module skew_transpose_buf_chk #(
    parameter int LANES = 4,
    parameter int ROW_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic             frame_done,
    input logic [ROW_W-1:0] wr_row,
    input logic [ROW_W-1:0] rd_grp
);
    localparam logic [ROW_W-1:0] LAST = ROW_W'(LANES - 1);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: nothing is presented in the first cycle after reset is released
    always_ff @(posedge clk) begin
        if (!rst && rst_q) begin
            a_r1_quiet_after_reset: assert (!out_valid);
        end
    end

    // R3: a group run does not break before its last group
    a_r3_run_unbroken: assert property (@(posedge clk) disable iff (rst)
        (out_valid && rd_grp != LAST) |=> out_valid);

    // R3: the run ends after the last group unless a new frame is ready
    a_r3_run_ends: assert property (@(posedge clk) disable iff (rst)
        (out_valid && rd_grp == LAST && !frame_done) |=> !out_valid);

    // R4: a completed frame starts its read with group 0 on the next cycle
    a_r4_start_group0: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (out_valid && rd_grp == '0));

    // R5: an idle input cycle leaves the write row unchanged
    a_r5_idle_holds_row: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(wr_row));

    // R6: a new frame never completes while the older one still has groups to send
    a_r6_no_overrun: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (!out_valid || rd_grp == LAST));

endmodule

bind skew_transpose_buf skew_transpose_buf_chk #(
    .LANES (LANES),
    .ROW_W ($clog2(LANES))
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .frame_done (frame_done),
    .wr_row     (wr_row),
    .rd_grp     (rd_grp)
);

// File: tb/skew_transpose_buf_bench.sv
`timescale 1ns/1ps
module skew_transpose_buf_bench;
    localparam int L  = 4;
    localparam int SW = 16;
    localparam int NVEC = 6;

    // Stimulus table: frame base value, idle cycles between rows, idle cycles after frame
    localparam logic [15:0] VBASE [NVEC] = '{16'h0100, 16'h0200, 16'h0300, 16'h0400, 16'h0500, 16'h0600};
    localparam int          VGAP  [NVEC] = '{0, 0, 0, 1, 2, 0};
    localparam int          VIDLE [NVEC] = '{0, 0, 0, 3, 0, 6};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [L*SW-1:0] in_re = '0;
    logic [L*SW-1:0] in_im = '0;
    logic            out_valid;
    logic [L*SW-1:0] out_re;
    logic [L*SW-1:0] out_im;

    always #2.5 clk = ~clk;

    skew_transpose_buf #(.LANES(L), .SAMPLE_W(SW)) u_skew_transpose_buf (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [15:0] exp_base [16];
    bit          gap_frame [16];
    int          drv_frame = 0;
    int          mon_frame = 0;
    int          mon_grp   = 0;
    int          run_len   = 0;
    int          max_run   = 0;
    bit          done      = 1'b0;

    function automatic logic [15:0] samp_re(input logic [15:0] base, input int k);
        return base + 16'(k);
    endfunction
    function automatic logic [15:0] samp_im(input logic [15:0] base, input int k);
        return 16'(base * 3) ^ 16'(16'h7000 + 7 * k);
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_row(input logic [15:0] base, input int r);
        in_valid = 1'b1;
        for (int j = 0; j < L; j++) begin
            in_re[j*SW +: SW] = samp_re(base, r*L + j);
            in_im[j*SW +: SW] = samp_im(base, r*L + j);
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic idle_garbage(input int n);
        for (int c = 0; c < n; c++) begin
            in_valid = 1'b0;
            in_re = {$urandom, $urandom};
            in_im = {$urandom, $urandom};
            @(posedge clk); #1;
        end
    endtask

    task automatic send_frame(input logic [15:0] base, input int gap);
        exp_base[drv_frame]  = base;
        gap_frame[drv_frame] = (gap > 0);
        drv_frame++;
        for (int r = 0; r < L; r++) begin
            drive_row(base, r);
            if (r != L-1) idle_garbage(gap);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Output monitor: R2 mapping, R3 ordering and run length, R5 for gapped frames
    always @(negedge clk) begin
        if (rst) begin
            mon_grp = 0;
            run_len = 0;
        end else if (!done) begin
            if (out_valid) begin
                logic [L*SW-1:0] er, ei;
                for (int t = 0; t < L; t++) begin
                    er[t*SW +: SW] = samp_re(exp_base[mon_frame], mon_grp + L*t);
                    ei[t*SW +: SW] = samp_im(exp_base[mon_frame], mon_grp + L*t);
                end
                check({out_im, out_re} === {ei, er},
                      gap_frame[mon_frame] ? "R5 gapped frame group" : "R2 group lanes",
                      {out_im, out_re}, {ei, er});
                run_len++;
                if (run_len > max_run) max_run = run_len;
                mon_grp++;
                if (mon_grp == L) begin
                    mon_grp = 0;
                    mon_frame++;
                end
            end else begin
                if (mon_grp != 0) check(1'b0, "R3 run broken early", 0, 1);
                run_len = 0;
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid === 1'b0, "R1 reset state", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 after reset", out_valid, 0);
        @(posedge clk); #1;

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            send_frame(VBASE[v], VGAP[v]);
            idle_garbage(VIDLE[v]);
        end
        idle_garbage(8);
        check(mon_frame == NVEC, "R3 all table frames in order", mon_frame, NVEC);
        check(max_run >= 3*L, "R6 back-to-back run without bubble", max_run, 3*L);

        // R4: latency edge
        exp_base[drv_frame]  = 16'h0900;
        gap_frame[drv_frame] = 1'b0;
        drv_frame++;
        for (int r = 0; r < L-1; r++) drive_row(16'h0900, r);
        @(negedge clk);
        check(out_valid === 1'b0, "R4 no output before last row", out_valid, 0);
        @(posedge clk); #1;
        drive_row(16'h0900, L-1);
        @(negedge clk);
        check(out_valid === 1'b1, "R4 valid right after last row", out_valid, 1);
        check(out_re[SW-1:0] === 16'h0900, "R4 group0 lane0", out_re[SW-1:0], 16'h0900);
        @(posedge clk); #1;
        idle_garbage(8);

        // R1: reset mid-frame drops the partial rows
        drive_row(16'h0A00, 0);
        drive_row(16'h0A00, 1);
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 idle after mid-frame reset", out_valid, 0);
        @(posedge clk); #1;
        send_frame(16'h0B00, 0);
        idle_garbage(8);
        check(mon_frame == drv_frame, "R1 clean frame after reset", mon_frame, drv_frame);

        done = 1'b1;
        report();
    end

endmodule